// File: doc/BRIEF.md
# Programmable-Priority Reference Clock Selector

This block chooses which of five reference clock inputs drives each of two independent timing paths, a main path and an auxiliary path. Every path has a 4-bit mode field. A value from 1 to 5 forces the input with that index. Any other value lets the block choose automatically. In that case it takes the input with the best programmed priority among the inputs that an external quality monitor currently marks as usable. When several usable inputs share the best priority, the smallest fixed index wins.

Configuration goes through a small synchronous register window. One bank bit decides whether accesses to the mode field and the priority nibbles reach the main-path copy or the auxiliary-path copy. Each path drives a registered selected index, a no-reference flag and a one-cycle change strobe. The clock switching itself and the quality monitor are outside this block.

Top module: `refsel_top`

## Requirements
- R1: After reset both paths are in automatic mode, every priority nibble holds 1, the bank bit is 0, and each path outputs index 0 with no-reference high and change low.
- R2: A mode field of 1 to 5 makes the path output that index with no-reference low, whatever the `ref_ok` flags are.
- R3: A mode field of 0 selects automatic mode. Input index k (1 to 5) is flagged usable by `ref_ok[k-1]`. The path outputs the usable input with the numerically smallest nonzero priority.
- R4: A priority of 0 removes that input from automatic selection even when it is flagged usable.
- R5: Among usable inputs with equal best priority, the smallest index is output.
- R6: In automatic mode with no usable, nonzero-priority input, the path outputs index 0 with no-reference high.
- R7: Mode values 6 to 15 behave exactly like 0 (automatic).
- R8: Address 0 bit 0 is the bank bit (0 main, 1 auxiliary). Writes and reads at addresses 1 to 4 reach only the banked path's copy, and the other path's outputs are unaffected.
- R9: Address 1 bits 3:0 hold the mode field. Addresses 2, 3 and 4 hold the priorities of index pairs (1,2), (3,4) and (5): the lower index sits in bits 3:0 and the higher in bits 7:4. `cfg_rdata` shows the addressed register one cycle after the address is presented. Unused bits read 0.
- R10: The selected index is registered. A change of `ref_ok` shows at the output after the next clock edge. A register write shows after the edge that follows the write edge.
- R11: A path's change strobe is high for exactly the cycle in which its selected index differs from its value in the previous cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_addr | input | 3 | Register address |
| cfg_wr | input | 1 | Write enable |
| cfg_wdata | input | 8 | Write data |
| cfg_rdata | output | 8 | Registered read data |
| ref_ok | input | 5 | Per-input usable flags from the quality monitor |
| main_sel | output | 3 | Main path selected index (0 = none) |
| main_change | output | 1 | Main path selection changed this cycle |
| main_noref | output | 1 | Main path has no usable reference |
| aux_sel | output | 3 | Auxiliary path selected index (0 = none) |
| aux_change | output | 1 | Auxiliary path selection changed this cycle |
| aux_noref | output | 1 | Auxiliary path has no usable reference |

## Verification
The bench sweeps all 32 `ref_ok` patterns under several priority sets. These sets include full ties, excluded inputs and all-zero priorities. A wrong tie-break would show up as a higher index, and a design that ignores zero priority would pick an excluded input. Every one of the 16 mode values is tried. A compare that counts 6 to 15 as forcing would output an index of 6 or more, and one that respects the flags in forced mode would drop to 0. Bank isolation is checked by programming the auxiliary copy and watching that the main outputs and readback stay put, since a missing bank decode corrupts the other path. Write-to-output latency and the strobe width are checked edge by edge, which catches an extra or a missing pipeline stage.

// File: rtl/refsel_pkg.sv
package refsel_pkg;
    localparam int unsigned NUM_INPUTS     = 5;
    localparam int unsigned PRIO_BITS      = 4;
    localparam int unsigned MODE_BITS      = 4;
    localparam int unsigned DATA_BITS      = 8;
    localparam int unsigned ADDR_BITS      = 3;
    localparam int unsigned NUM_PATHS      = 2;

    // register window layout
    localparam int unsigned ADDR_BANK      = 0;
    localparam int unsigned ADDR_MODE      = 1;
    localparam int unsigned ADDR_PRIO_BASE = 2;

    typedef enum logic {
        PATH_MAIN = 1'b0,
        PATH_AUX  = 1'b1
    } path_e;
endpackage

// File: rtl/refsel_arbiter.sv
// Picks the usable input with the smallest nonzero priority value;
// a strict compare in ascending index order keeps the lowest index on ties.
module refsel_arbiter #(
    parameter int unsigned NUM_IN = 5,
    parameter int unsigned PRIO_W = 4,
    parameter int unsigned IDX_W  = 3
) (
    input  logic [NUM_IN-1:0]             usable,
    input  logic [NUM_IN-1:0][PRIO_W-1:0] prio,
    output logic [IDX_W-1:0]              best_idx,
    output logic                          found
);
    logic [PRIO_W-1:0] best_prio;

    always_comb begin
        found     = 1'b0;
        best_idx  = '0;
        best_prio = '1;
        for (int i = 0; i < int'(NUM_IN); i++) begin
            if (usable[i] && (prio[i] != '0) && (!found || (prio[i] < best_prio))) begin
                found     = 1'b1;
                best_prio = prio[i];
                best_idx  = IDX_W'(i + 1);
            end
        end
    end
endmodule

// File: rtl/refsel_path.sv
module refsel_path #(
    parameter int unsigned NUM_IN = 5,
    parameter int unsigned PRIO_W = 4,
    parameter int unsigned MODE_W = 4,
    parameter int unsigned IDX_W  = 3
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic [NUM_IN-1:0]             usable,
    input  logic [NUM_IN-1:0][PRIO_W-1:0] prio,
    input  logic [MODE_W-1:0]             mode,
    output logic [IDX_W-1:0]              sel,
    output logic                          change,
    output logic                          noref
);
    typedef struct packed {
        logic [IDX_W-1:0] sel;
        logic             change;
        logic             noref;
    } path_state_t;

    path_state_t state_d, state_q;

    logic [IDX_W-1:0] auto_idx;
    logic             auto_found;
    logic             forced;

    refsel_arbiter #(
        .NUM_IN (NUM_IN),
        .PRIO_W (PRIO_W),
        .IDX_W  (IDX_W)
    ) u_arb (
        .usable   (usable),
        .prio     (prio),
        .best_idx (auto_idx),
        .found    (auto_found)
    );

    always_comb begin
        forced = (mode != '0) && (mode <= MODE_W'(NUM_IN));
        state_d = state_q;
        if (forced) begin
            state_d.sel   = IDX_W'(mode);
            state_d.noref = 1'b0;
        end else begin
            state_d.sel   = auto_found ? auto_idx : '0;
            state_d.noref = !auto_found;
        end
        state_d.change = (state_d.sel != state_q.sel);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q.sel    <= '0;
            state_q.change <= 1'b0;
            state_q.noref  <= 1'b1;
        end else begin
            state_q <= state_d;
        end
    end

    assign sel    = state_q.sel;
    assign change = state_q.change;
    assign noref  = state_q.noref;
endmodule

// File: rtl/refsel_regs.sv
module refsel_regs
    import refsel_pkg::*;
#(
    parameter int unsigned NUM_IN = 5,
    parameter int unsigned PRIO_W = 4,
    parameter int unsigned MODE_W = 4,
    parameter int unsigned DATA_W = 8,
    parameter int unsigned ADDR_W = 3
) (
    input  logic                                    clk,
    input  logic                                    rst_n,
    input  logic [ADDR_W-1:0]                       addr,
    input  logic                                    wr,
    input  logic [DATA_W-1:0]                       wdata,
    output logic [DATA_W-1:0]                       rdata,
    output logic [NUM_PATHS-1:0][MODE_W-1:0]        mode,
    output logic [NUM_PATHS-1:0][NUM_IN-1:0][PRIO_W-1:0] prio
);
    localparam int unsigned PER_WORD = DATA_W / PRIO_W;

    typedef struct packed {
        logic                                         bank;
        logic [NUM_PATHS-1:0][MODE_W-1:0]             mode;
        logic [NUM_PATHS-1:0][NUM_IN-1:0][PRIO_W-1:0] prio;
        logic [DATA_W-1:0]                            rdata;
    } regs_t;

    regs_t regs_d, regs_q;

    function automatic regs_t reset_value();
        regs_t r;
        r = '0;
        for (int p = 0; p < int'(NUM_PATHS); p++)
            for (int i = 0; i < int'(NUM_IN); i++)
                r.prio[p][i] = PRIO_W'(1);
        return r;
    endfunction

    always_comb begin
        regs_d       = regs_q;
        regs_d.rdata = '0;

        // registered read of the banked copy
        if (addr == ADDR_W'(ADDR_BANK))
            regs_d.rdata[0] = regs_q.bank;
        if (addr == ADDR_W'(ADDR_MODE))
            regs_d.rdata[MODE_W-1:0] = regs_q.mode[regs_q.bank];
        for (int i = 0; i < int'(NUM_IN); i++) begin
            if (addr == ADDR_W'(ADDR_PRIO_BASE + i / PER_WORD))
                regs_d.rdata[(i % PER_WORD) * PRIO_W +: PRIO_W] = regs_q.prio[regs_q.bank][i];
        end

        if (wr) begin
            if (addr == ADDR_W'(ADDR_BANK))
                regs_d.bank = wdata[0];
            if (addr == ADDR_W'(ADDR_MODE))
                regs_d.mode[regs_q.bank] = wdata[MODE_W-1:0];
            for (int i = 0; i < int'(NUM_IN); i++) begin
                if (addr == ADDR_W'(ADDR_PRIO_BASE + i / PER_WORD))
                    regs_d.prio[regs_q.bank][i] = wdata[(i % PER_WORD) * PRIO_W +: PRIO_W];
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) regs_q <= reset_value();
        else        regs_q <= regs_d;
    end

    assign rdata = regs_q.rdata;
    assign mode  = regs_q.mode;
    assign prio  = regs_q.prio;
endmodule

// File: rtl/refsel_top.sv
module refsel_top
    import refsel_pkg::*;
#(
    parameter  int unsigned NUM_IN = NUM_INPUTS,
    parameter  int unsigned PRIO_W = PRIO_BITS,
    parameter  int unsigned MODE_W = MODE_BITS,
    parameter  int unsigned DATA_W = DATA_BITS,
    parameter  int unsigned ADDR_W = ADDR_BITS,
    localparam int unsigned IDX_W  = $clog2(NUM_IN + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] cfg_addr,
    input  logic              cfg_wr,
    input  logic [DATA_W-1:0] cfg_wdata,
    output logic [DATA_W-1:0] cfg_rdata,
    input  logic [NUM_IN-1:0] ref_ok,
    output logic [IDX_W-1:0]  main_sel,
    output logic              main_change,
    output logic              main_noref,
    output logic [IDX_W-1:0]  aux_sel,
    output logic              aux_change,
    output logic              aux_noref
);
    logic [NUM_PATHS-1:0][MODE_W-1:0]             mode_w;
    logic [NUM_PATHS-1:0][NUM_IN-1:0][PRIO_W-1:0] prio_w;
    logic [NUM_PATHS-1:0][IDX_W-1:0]              sel_w;
    logic [NUM_PATHS-1:0]                         change_w;
    logic [NUM_PATHS-1:0]                         noref_w;

    refsel_regs #(
        .NUM_IN (NUM_IN),
        .PRIO_W (PRIO_W),
        .MODE_W (MODE_W),
        .DATA_W (DATA_W),
        .ADDR_W (ADDR_W)
    ) u_regs (
        .clk   (clk),
        .rst_n (rst_n),
        .addr  (cfg_addr),
        .wr    (cfg_wr),
        .wdata (cfg_wdata),
        .rdata (cfg_rdata),
        .mode  (mode_w),
        .prio  (prio_w)
    );

    for (genvar p = 0; p < int'(NUM_PATHS); p++) begin : g_path
        refsel_path #(
            .NUM_IN (NUM_IN),
            .PRIO_W (PRIO_W),
            .MODE_W (MODE_W),
            .IDX_W  (IDX_W)
        ) u_path (
            .clk    (clk),
            .rst_n  (rst_n),
            .usable (ref_ok),
            .prio   (prio_w[p]),
            .mode   (mode_w[p]),
            .sel    (sel_w[p]),
            .change (change_w[p]),
            .noref  (noref_w[p])
        );
    end

    assign main_sel    = sel_w[PATH_MAIN];
    assign main_change = change_w[PATH_MAIN];
    assign main_noref  = noref_w[PATH_MAIN];
    assign aux_sel     = sel_w[PATH_AUX];
    assign aux_change  = change_w[PATH_AUX];
    assign aux_noref   = noref_w[PATH_AUX];
endmodule

// File: rtl/refsel_checker.sv
module refsel_checker #(
    parameter int unsigned NUM_IN = 5,
    parameter int unsigned MODE_W = 4,
    parameter int unsigned IDX_W  = 3
) (
    input logic              clk,
    input logic              rst_n,
    input logic [MODE_W-1:0] main_mode,
    input logic [IDX_W-1:0]  main_sel,
    input logic              main_change,
    input logic              main_noref,
    input logic [IDX_W-1:0]  aux_sel,
    input logic              aux_change,
    input logic              aux_noref
);
    // R11: any index change is strobed, and the strobe only marks a change
    a_r11_main_change_seen: assert property (@(posedge clk) disable iff (!rst_n)
        (main_sel != $past(main_sel)) |-> main_change);
    a_r11_main_change_real: assert property (@(posedge clk) disable iff (!rst_n)
        main_change |-> (main_sel != $past(main_sel)));
    a_r11_aux_change_seen: assert property (@(posedge clk) disable iff (!rst_n)
        (aux_sel != $past(aux_sel)) |-> aux_change);
    a_r11_aux_change_real: assert property (@(posedge clk) disable iff (!rst_n)
        aux_change |-> (aux_sel != $past(aux_sel)));

    // R6: no-reference always comes with index 0
    a_r6_main_noref_zero: assert property (@(posedge clk) disable iff (!rst_n)
        main_noref |-> (main_sel == '0));
    a_r6_aux_noref_zero: assert property (@(posedge clk) disable iff (!rst_n)
        aux_noref |-> (aux_sel == '0));

    // R3: an index beyond the input count is never produced
    a_r3_main_range: assert property (@(posedge clk) disable iff (!rst_n)
        main_sel <= IDX_W'(NUM_IN));
    a_r3_aux_range: assert property (@(posedge clk) disable iff (!rst_n)
        aux_sel <= IDX_W'(NUM_IN));

    // R2: a forcing mode value appears at the output one edge later
    a_r2_main_forced: assert property (@(posedge clk) disable iff (!rst_n)
        ((main_mode != '0) && (main_mode <= MODE_W'(NUM_IN)))
        |=> ((main_sel == IDX_W'($past(main_mode))) && !main_noref));
endmodule

bind refsel_top refsel_checker #(
    .NUM_IN (NUM_IN),
    .MODE_W (MODE_W),
    .IDX_W  (IDX_W)
) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .main_mode   (mode_w[0]),
    .main_sel    (main_sel),
    .main_change (main_change),
    .main_noref  (main_noref),
    .aux_sel     (aux_sel),
    .aux_change  (aux_change),
    .aux_noref   (aux_noref)
);

// File: tb/refsel_top_bench.sv
`timescale 1ns/1ps
module refsel_top_bench;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [2:0] cfg_addr = '0;
    logic       cfg_wr = 1'b0;
    logic [7:0] cfg_wdata = '0;
    logic [7:0] cfg_rdata;
    logic [4:0] ref_ok = '0;
    logic [2:0] main_sel, aux_sel;
    logic       main_change, aux_change, main_noref, aux_noref;

    int n_tests = 0;
    int n_fail  = 0;
    bit done    = 0;

    // bench-side model of the register contents
    int bank_m;
    int mode_m [2];
    int prio_m [2][5];
    int prev_m [2];

    always #2.5 clk = ~clk;

    refsel_top u_refsel_top (
        .clk(clk), .rst_n(rst_n), .cfg_addr(cfg_addr), .cfg_wr(cfg_wr),
        .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata), .ref_ok(ref_ok),
        .main_sel(main_sel), .main_change(main_change), .main_noref(main_noref),
        .aux_sel(aux_sel), .aux_change(aux_change), .aux_noref(aux_noref)
    );

    task automatic chk(input string req, input string what, input int act, input int exp);
        n_tests++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    function automatic int model_sel(input int p, input logic [4:0] q);
        int best = 16;
        int idx  = 0;
        if (mode_m[p] >= 1 && mode_m[p] <= 5) return mode_m[p];
        for (int i = 0; i < 5; i++)
            if (q[i] && prio_m[p][i] != 0 && prio_m[p][i] < best) begin
                best = prio_m[p][i];
                idx  = i + 1;
            end
        return idx;
    endfunction

    function automatic int path_sel(input int p);
        return (p == 0) ? int'(main_sel) : int'(aux_sel);
    endfunction
    function automatic int path_noref(input int p);
        return (p == 0) ? int'(main_noref) : int'(aux_noref);
    endfunction
    function automatic int path_change(input int p);
        return (p == 0) ? int'(main_change) : int'(aux_change);
    endfunction

    // drive usable flags, check both paths one edge later
    task automatic apply(input logic [4:0] q, input string req);
        @(negedge clk);
        ref_ok = q;
        @(posedge clk);
        #1;
        for (int p = 0; p < 2; p++) begin
            int e = model_sel(p, q);
            bit forced = (mode_m[p] >= 1 && mode_m[p] <= 5);
            chk(req, $sformatf("path%0d sel q=%b", p, q), path_sel(p), e);
            chk(req, $sformatf("path%0d noref q=%b", p, q), path_noref(p),
                (!forced && e == 0) ? 1 : 0);
            chk("R11", $sformatf("path%0d change q=%b", p, q), path_change(p),
                (e != prev_m[p]) ? 1 : 0);
            prev_m[p] = e;
        end
    endtask

    task automatic wr(input int a, input int d);
        @(negedge clk);
        cfg_addr  = 3'(a);
        cfg_wdata = 8'(d);
        cfg_wr    = 1'b1;
        if (a == 0) bank_m = d & 1;
        if (a == 1) mode_m[bank_m] = d & 15;
        if (a >= 2 && a <= 4) begin
            prio_m[bank_m][(a-2)*2] = d & 15;
            if (a != 4) prio_m[bank_m][(a-2)*2+1] = (d >> 4) & 15;
        end
        @(negedge clk);
        cfg_wr = 1'b0;
    endtask

    task automatic settle(input string req);
        repeat (3) @(posedge clk);
        #1;
        for (int p = 0; p < 2; p++) begin
            prev_m[p] = model_sel(p, ref_ok);
            chk(req, $sformatf("path%0d settled sel", p), path_sel(p), prev_m[p]);
        end
    endtask

    task automatic rd(input int a, input int exp, input string req);
        @(negedge clk);
        cfg_addr = 3'(a);
        @(posedge clk);
        #1;
        chk(req, $sformatf("read addr %0d", a), int'(cfg_rdata), exp);
    endtask

    task automatic sweep(input string req);
        for (int q = 0; q < 32; q++) apply(5'(q), req);
    endtask

    task automatic summary();
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    endtask

    initial begin
        bank_m = 0;
        for (int p = 0; p < 2; p++) begin
            mode_m[p] = 0;
            prev_m[p] = 0;
            for (int i = 0; i < 5; i++) prio_m[p][i] = 1;
        end
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        #1;
        // R1 reset state
        chk("R1", "main sel", int'(main_sel), 0);
        chk("R1", "main noref", int'(main_noref), 1);
        chk("R1", "main change", int'(main_change), 0);
        chk("R1", "aux sel", int'(aux_sel), 0);
        chk("R1", "aux noref", int'(aux_noref), 1);
        chk("R1", "aux change", int'(aux_change), 0);
        rd(0, 0, "R1");
        rd(1, 0, "R1");
        rd(2, 8'h11, "R1");
        rd(4, 8'h01, "R9 R1");
        rd(6, 0, "R9");

        // default priorities: all equal, tie to lowest index (R5)
        sweep("R5 R3");

        // distinct priorities on main
        wr(2, 8'h13); wr(3, 8'h52); wr(4, 8'h04);
        rd(2, 8'h13, "R9"); rd(3, 8'h52, "R9"); rd(4, 8'h04, "R9");
        settle("R3");
        sweep("R3 R6");

        // ties plus an excluded input
        wr(2, 8'h22); wr(3, 8'h20); wr(4, 8'h07);
        settle("R4");
        sweep("R4 R5");

        // all excluded
        wr(2, 8'h00); wr(3, 8'h00); wr(4, 8'h00);
        settle("R4");
        sweep("R6 R4");

        // every mode value on main
        wr(2, 8'h31); wr(3, 8'h21); wr(4, 8'h05);
        for (int f = 0; f < 16; f++) begin
            wr(1, f);
            settle((f >= 1 && f <= 5) ? "R2" : "R7");
            apply(5'b00000, (f >= 1 && f <= 5) ? "R2" : "R7 R6");
            apply(5'b10101, (f >= 1 && f <= 5) ? "R2" : "R7");
            apply(5'b11111, (f >= 1 && f <= 5) ? "R2" : "R7");
            apply(5'b01010, (f >= 1 && f <= 5) ? "R2" : "R7");
        end
        wr(1, 0);
        settle("R7");

        // auxiliary bank
        wr(0, 1);
        rd(0, 1, "R8");
        rd(2, 8'h11, "R8");
        wr(2, 8'h40); wr(3, 8'h14); wr(4, 8'h02);
        rd(2, 8'h40, "R8"); rd(3, 8'h14, "R8"); rd(4, 8'h02, "R8");
        settle("R8");
        sweep("R8 R3");
        wr(1, 3);
        rd(1, 3, "R8");
        settle("R8");
        apply(5'b00000, "R8 R2");
        apply(5'b11011, "R8 R2");
        wr(1, 0);
        wr(0, 0);
        rd(1, 0, "R8");
        rd(2, 8'h31, "R8");
        rd(4, 8'h05, "R8");
        settle("R8");

        // R10 write latency and R11 strobe width on main
        apply(5'b11111, "R10");
        wr(1, 4);
        chk("R10", "main sel one edge after write", int'(main_sel), prev_m[0]);
        @(posedge clk); #1;
        chk("R10", "main sel two edges after write", int'(main_sel), 4);
        chk("R11", "main change on switch", int'(main_change), 1);
        @(posedge clk); #1;
        chk("R11", "main change cleared", int'(main_change), 0);
        chk("R10", "main sel held", int'(main_sel), 4);
        prev_m[0] = 4;
        apply(5'b00000, "R2 R10");

        done = 1;
        summary();
        $finish;
    end

    initial begin
        #(5.0 * 150000);
        if (!done) begin
            n_tests++;
            n_fail++;
            $display("FAIL watchdog: actual hung expected finish");
            summary();
            $finish;
        end
    end
endmodule